// File: doc/BRIEF.md
# Memory-mapped IDE register bridge

This block connects a big-endian memory-mapped host bus to an ATA-style task-file register interface. The host presents an address, a direction, an access size (byte, halfword or word) and write data. The bridge decodes the low bits of the address into a register slot and decides whether the access reaches the device side. If it does, the bridge issues a single request strobe on a downstream port. That strobe carries a normalized register index, the direction, the size and the lane-formatted write data.

Byte accesses reach the seven command-block registers and the device-control / alternate-status register. The control register answers at two slots. Halfword and word accesses reach only the data port, and their data is byte-reversed in both directions so that a big-endian host sees the little-endian data stream in order. An access to any other slot is dropped. A dropped write has no effect, and a dropped read returns all ones for its width. Either way the host is acknowledged straight away, so the bus never stalls.

Top module: `ide_mmio_bridge`

## Requirements
- R1: Only host address bits [11:4] select the register slot (16-byte stride, 4 KB window). Bits above bit 11 and bits [3:0] have no effect on routing.
- R2: A byte write to slot 1..7 produces one downstream write strobe with index equal to the slot, size code 0 and the host's low byte on tf_wdata[7:0] (upper bits zero). The host is acknowledged one cycle after the access is accepted.
- R3: A byte access to slot 8 or slot 22 goes to the control register. It is presented downstream as index 8, both for writes (device control) and reads (alternate status).
- R4: A byte read from slot 1..7 or from a control slot returns tf_rdata[7:0] zero-extended on hst_rdata.
- R5: A byte access to any slot other than 1..8 and 22 produces no downstream strobe. A write is ignored and a read returns 0x000000FF. Both are acknowledged one cycle after acceptance.
- R6: Halfword (size code 1) and word (size code 2) accesses reach the device only at slot 0, as index 0. At any other slot they produce no strobe, and reads return 0x0000FFFF or 0xFFFFFFFF respectively.
- R7: Halfword data-port data is byte-reversed both ways. Host write 0xAABB appears as tf_wdata 0x0000BBAA, and device data 0x1234 returns as 0x00003412.
- R8: Word data-port data is fully byte-reversed both ways. Host byte 3 maps to device byte 0, and so on in mirror order.
- R9: Every accepted access produces at most one downstream strobe, and hst_ack is a single-cycle pulse per access.
- R10: A forwarded read is acknowledged only once tf_rvalid has been seen, one cycle after it, with the formatted data.
- R11: Reset clears any pending downstream read. A response arriving after reset does not produce a host acknowledge, and hst_ack and tf_req are low out of reset.
- R12: Size code 3 is reserved. It is never forwarded, and a read with it returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hst_req | input | 1 | Host access request, held until hst_ack |
| hst_we | input | 1 | Host direction, 1 = write |
| hst_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| hst_addr | input | AW | Host byte address |
| hst_wdata | input | 32 | Host write data, right-aligned |
| hst_ack | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Read data, valid with hst_ack |
| tf_req | output | 1 | Downstream request strobe |
| tf_we | output | 1 | Downstream direction, 1 = write |
| tf_size | output | 2 | Downstream size code |
| tf_idx | output | 4 | Register index: 0 data, 1..7 command block, 8 control |
| tf_wdata | output | 32 | Lane-formatted write data |
| tf_rvalid | input | 1 | Downstream read response valid |
| tf_rdata | input | 32 | Downstream read data, right-aligned |

## Verification
The hardest situation to reach is a reset that lands while a forwarded read is still waiting for its response, followed by that stale response arriving once the bridge is idle again. The bench's device model answers reads after a programmable delay and is not cleared by the bridge's reset. A directed case starts a read, holds the response back, pulses reset during the wait, and then watches the acknowledge line while the late tf_rvalid arrives. Random traffic mixes slot 22 aliases, far-upper address bits, reserved sizes and variable response delays around that case.

// File: rtl/ide_br_pkg.sv
package ide_br_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_TASK = 2'd1,
    RT_CTRL = 2'd2,
    RT_DATA = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } ctrl_state_e;

  localparam int unsigned TF_IDX_W = 4;
  localparam logic [TF_IDX_W-1:0] TF_IDX_DATA = 4'd0;
  localparam logic [TF_IDX_W-1:0] TF_IDX_CTRL = 4'd8;

  typedef struct packed {
    route_e                route;
    logic [TF_IDX_W-1:0]   idx;
  } route_t;

endpackage

// File: rtl/ide_br_decode.sv
module ide_br_decode
  import ide_br_pkg::*;
#(
  parameter int unsigned WIN_BITS    = 12,
  parameter int unsigned STRIDE_BITS = 4,
  parameter int unsigned TASK_LO     = 1,
  parameter int unsigned TASK_HI     = 7,
  parameter int unsigned CTRL_SLOT_A = 8,
  parameter int unsigned CTRL_SLOT_B = 22
) (
  input  logic [WIN_BITS-1:0] win_addr,
  input  acc_size_e           size,
  output route_t              dec
);

  localparam int unsigned SLOT_W = WIN_BITS - STRIDE_BITS;

  logic [SLOT_W-1:0] slot;
  logic              is_task;
  logic              is_ctrl;
  logic              is_data;
  logic              addr_unused;

  assign slot        = win_addr[WIN_BITS-1:STRIDE_BITS];
  assign addr_unused = ^win_addr[STRIDE_BITS-1:0];

  assign is_task = (slot >= SLOT_W'(TASK_LO)) && (slot <= SLOT_W'(TASK_HI));
  assign is_ctrl = (slot == SLOT_W'(CTRL_SLOT_A)) || (slot == SLOT_W'(CTRL_SLOT_B));
  assign is_data = (slot == '0);

  always_comb begin
    dec.route = RT_DROP;
    dec.idx   = TF_IDX_DATA;
    unique case (size)
      SZ_BYTE: begin
        if (is_task) begin
          dec.route = RT_TASK;
          dec.idx   = slot[TF_IDX_W-1:0];
        end else if (is_ctrl) begin
          dec.route = RT_CTRL;
          dec.idx   = TF_IDX_CTRL;
        end
      end
      SZ_HALF, SZ_WORD: begin
        if (is_data) begin
          dec.route = RT_DATA;
          dec.idx   = TF_IDX_DATA;
        end
      end
      default: begin
        dec.route = RT_DROP;
        dec.idx   = TF_IDX_DATA;
      end
    endcase
  end

endmodule

// File: rtl/ide_br_bswap.sv
module ide_br_bswap #(
  parameter int unsigned BYTES = 4
) (
  input  logic [8*BYTES-1:0] din,
  output logic [8*BYTES-1:0] dout
);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign dout[8*g +: 8] = din[8*(BYTES-1-g) +: 8];
  end

endmodule

// File: rtl/ide_br_lanes.sv
module ide_br_lanes
  import ide_br_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  acc_size_e        wr_size,
  input  acc_size_e        rd_size,
  input  logic [DW-1:0]    host_wd,
  input  logic [DW-1:0]    dev_rd,
  output logic [DW-1:0]    dev_wd,
  output logic [DW-1:0]    host_rd,
  output logic [DW-1:0]    fill
);

  localparam int unsigned HW    = 16;
  localparam int unsigned BYTES = DW / 8;

  logic [HW-1:0] half_wr_sw;
  logic [HW-1:0] half_rd_sw;
  logic [DW-1:0] word_wr_sw;
  logic [DW-1:0] word_rd_sw;

  ide_br_bswap #(.BYTES(HW/8)) u_half_wr (.din(host_wd[HW-1:0]), .dout(half_wr_sw));
  ide_br_bswap #(.BYTES(HW/8)) u_half_rd (.din(dev_rd[HW-1:0]),  .dout(half_rd_sw));
  ide_br_bswap #(.BYTES(BYTES)) u_word_wr (.din(host_wd),        .dout(word_wr_sw));
  ide_br_bswap #(.BYTES(BYTES)) u_word_rd (.din(dev_rd),         .dout(word_rd_sw));

  always_comb begin
    unique case (wr_size)
      SZ_BYTE: dev_wd = DW'(host_wd[7:0]);
      SZ_HALF: dev_wd = DW'(half_wr_sw);
      default: dev_wd = word_wr_sw;
    endcase
  end

  always_comb begin
    unique case (rd_size)
      SZ_BYTE: host_rd = DW'(dev_rd[7:0]);
      SZ_HALF: host_rd = DW'(half_rd_sw);
      default: host_rd = word_rd_sw;
    endcase
  end

  always_comb begin
    unique case (wr_size)
      SZ_BYTE: fill = DW'(8'hFF);
      SZ_HALF: fill = DW'(16'hFFFF);
      default: fill = '1;
    endcase
  end

endmodule

// File: rtl/ide_br_ctrl.sv
module ide_br_ctrl
  import ide_br_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_req,
  input  logic                hst_we,
  input  acc_size_e           hst_size,
  input  route_t              dec,
  input  logic [DW-1:0]       dev_wd,
  input  logic [DW-1:0]       host_rd,
  input  logic [DW-1:0]       fill,
  input  logic                tf_rvalid,
  output logic                hst_ack,
  output logic [DW-1:0]       hst_rdata,
  output logic                tf_req,
  output logic                tf_we,
  output acc_size_e           tf_size,
  output logic [TF_IDX_W-1:0] tf_idx,
  output logic [DW-1:0]       tf_wdata
);

  ctrl_state_e st_q, st_d;
  logic        req_d;
  logic        ack_d;
  logic        cap_en;
  logic        rd_en;
  logic [DW-1:0] rd_d;
  logic        accept;

  assign accept = (st_q == ST_IDLE) && hst_req;

  always_comb begin
    st_d   = st_q;
    req_d  = 1'b0;
    ack_d  = 1'b0;
    cap_en = 1'b0;
    rd_en  = 1'b0;
    rd_d   = host_rd;
    unique case (st_q)
      ST_IDLE: begin
        if (hst_req) begin
          if (dec.route == RT_DROP) begin
            ack_d = 1'b1;
            rd_en = !hst_we;
            rd_d  = fill;
            st_d  = ST_DONE;
          end else begin
            req_d  = 1'b1;
            cap_en = 1'b1;
            if (hst_we) begin
              ack_d = 1'b1;
              st_d  = ST_DONE;
            end else begin
              st_d = ST_WAIT;
            end
          end
        end
      end
      ST_WAIT: begin
        if (tf_rvalid) begin
          ack_d = 1'b1;
          rd_en = 1'b1;
          rd_d  = host_rd;
          st_d  = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tf_req  <= 1'b0;
      hst_ack <= 1'b0;
    end else begin
      st_q    <= st_d;
      tf_req  <= req_d;
      hst_ack <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf_we    <= 1'b0;
      tf_size  <= SZ_BYTE;
      tf_idx   <= '0;
      tf_wdata <= '0;
    end else if (cap_en) begin
      tf_we    <= hst_we;
      tf_size  <= hst_size;
      tf_idx   <= dec.idx;
      tf_wdata <= hst_we ? dev_wd : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hst_rdata <= '0;
    end else if (rd_en) begin
      hst_rdata <= rd_d;
    end
  end

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tf_req |=> !tf_req);

  assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |=> !hst_ack);

  assert_drop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.route == RT_DROP) |=> (hst_ack && !tf_req));

  assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !tf_rvalid) |=> !hst_ack);

  assert_write_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_req && tf_we) |-> hst_ack);

endmodule

// File: rtl/ide_mmio_bridge.sv
module ide_mmio_bridge
  import ide_br_pkg::*;
#(
  parameter int unsigned AW          = 32,
  parameter int unsigned WIN_BITS    = 12,
  parameter int unsigned STRIDE_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_req,
  input  logic          hst_we,
  input  logic [1:0]    hst_size,
  input  logic [AW-1:0] hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic          hst_ack,
  output logic [31:0]   hst_rdata,
  output logic          tf_req,
  output logic          tf_we,
  output logic [1:0]    tf_size,
  output logic [3:0]    tf_idx,
  output logic [31:0]   tf_wdata,
  input  logic          tf_rvalid,
  input  logic [31:0]   tf_rdata
);

  localparam int unsigned DW = 32;

  acc_size_e   size_in;
  acc_size_e   size_out;
  route_t      dec;
  logic [DW-1:0] dev_wd;
  logic [DW-1:0] host_rd;
  logic [DW-1:0] fill;
  logic          addr_unused;

  assign size_in     = acc_size_e'(hst_size);
  assign tf_size     = size_out;
  assign addr_unused = ^hst_addr[AW-1:WIN_BITS];

  ide_br_decode #(
    .WIN_BITS   (WIN_BITS),
    .STRIDE_BITS(STRIDE_BITS)
  ) u_decode (
    .win_addr(hst_addr[WIN_BITS-1:0]),
    .size    (size_in),
    .dec     (dec)
  );

  ide_br_lanes #(.DW(DW)) u_lanes (
    .wr_size(size_in),
    .rd_size(size_out),
    .host_wd(hst_wdata),
    .dev_rd (tf_rdata),
    .dev_wd (dev_wd),
    .host_rd(host_rd),
    .fill   (fill)
  );

  ide_br_ctrl #(.DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .hst_req  (hst_req),
    .hst_we   (hst_we),
    .hst_size (size_in),
    .dec      (dec),
    .dev_wd   (dev_wd),
    .host_rd  (host_rd),
    .fill     (fill),
    .tf_rvalid(tf_rvalid),
    .hst_ack  (hst_ack),
    .hst_rdata(hst_rdata),
    .tf_req   (tf_req),
    .tf_we    (tf_we),
    .tf_size  (size_out),
    .tf_idx   (tf_idx),
    .tf_wdata (tf_wdata)
  );

  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tf_req |-> (tf_idx <= TF_IDX_CTRL));

  assert_ctrl_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_req && tf_idx == TF_IDX_CTRL) |-> (tf_size == SZ_BYTE));

  assert_data_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_req && tf_idx == TF_IDX_DATA) |-> (tf_size == SZ_HALF || tf_size == SZ_WORD));

  assert_half_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_req && tf_we && tf_size == SZ_HALF) |-> (tf_wdata[31:16] == 16'h0));

  assert_no_rsvd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tf_req |-> (tf_size != SZ_RSVD));

endmodule

// File: tb/sim_ide_mmio_bridge.sv
module sim_ide_mmio_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0;
  logic        hst_we = 1'b0;
  logic [1:0]  hst_size = 2'd0;
  logic [31:0] hst_addr = 32'd0;
  logic [31:0] hst_wdata = 32'd0;
  logic        hst_ack;
  logic [31:0] hst_rdata;
  logic        tf_req;
  logic        tf_we;
  logic [1:0]  tf_size;
  logic [3:0]  tf_idx;
  logic [31:0] tf_wdata;
  logic        tf_rvalid = 1'b0;
  logic [31:0] tf_rdata = 32'd0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int          strobes = 0;
  logic        cap_we = 1'b0;
  logic [1:0]  cap_size = 2'd0;
  logic [3:0]  cap_idx = 4'd0;
  logic [31:0] cap_wdata = 32'd0;
  logic [31:0] resp_word = 32'd0;
  int          resp_delay = 0;
  logic        rd_pend = 1'b0;
  int          rd_cnt = 0;

  always #2 clk = ~clk;

  ide_mmio_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .hst_req(hst_req), .hst_we(hst_we), .hst_size(hst_size),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_ack(hst_ack), .hst_rdata(hst_rdata),
    .tf_req(tf_req), .tf_we(tf_we), .tf_size(tf_size), .tf_idx(tf_idx),
    .tf_wdata(tf_wdata), .tf_rvalid(tf_rvalid), .tf_rdata(tf_rdata)
  );

  // device model: counts strobes, answers reads after resp_delay cycles
  always @(posedge clk) begin
    tf_rvalid <= 1'b0;
    if (tf_req) begin
      strobes   <= strobes + 1;
      cap_we    <= tf_we;
      cap_size  <= tf_size;
      cap_idx   <= tf_idx;
      cap_wdata <= tf_wdata;
      if (!tf_we) begin
        rd_pend <= 1'b1;
        rd_cnt  <= resp_delay;
      end
    end else if (rd_pend) begin
      if (rd_cnt == 0) begin
        tf_rvalid <= 1'b1;
        tf_rdata  <= resp_word;
        rd_pend   <= 1'b0;
      end else begin
        rd_cnt <= rd_cnt - 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act %0d exp <150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s act %h exp %h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_fwd(input logic [31:0] a, input logic [1:0] sz);
    logic [7:0] s;
    s = a[11:4];
    case (sz)
      2'd0:    return (s >= 8'd1 && s <= 8'd7) || s == 8'd8 || s == 8'd22;
      2'd1,
      2'd2:    return s == 8'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] exp_idx(input logic [31:0] a);
    return (a[11:4] == 8'd22) ? 4'd8 : a[7:4];
  endfunction

  function automatic logic [31:0] rev_fmt(input logic [1:0] sz, input logic [31:0] d);
    case (sz)
      2'd0:    return {24'h0, d[7:0]};
      2'd1:    return {16'h0, d[7:0], d[15:8]};
      default: return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endcase
  endfunction

  function automatic logic [31:0] exp_fill(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic do_acc(input string tag, input bit we, input logic [1:0] sz,
                        input logic [31:0] addr, input logic [31:0] wd,
                        input logic [31:0] resp, input int dly);
    int s0;
    int lat;
    logic [31:0] rd;
    bit f;
    resp_word  = resp;
    resp_delay = dly;
    @(negedge clk);
    s0 = strobes;
    hst_req = 1'b1; hst_we = we; hst_size = sz; hst_addr = addr; hst_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!hst_ack && lat < 64);
    rd = hst_rdata;
    hst_req = 1'b0;
    @(negedge clk);
    f = exp_fwd(addr, sz);
    chk(lat < 64, tag, "ack seen", 32'(lat), 32'd1);
    chk((strobes - s0) == (f ? 1 : 0), tag, "strobe count", 32'(strobes - s0), f ? 32'd1 : 32'd0);
    if (f) begin
      chk(cap_idx == exp_idx(addr), tag, "index", 32'(cap_idx), 32'(exp_idx(addr)));
      chk(cap_we == we && cap_size == sz, tag, "dir/size", {30'h0, cap_size} | (32'(cap_we) << 4),
          {30'h0, sz} | (32'(we) << 4));
      if (we) begin
        chk(cap_wdata == rev_fmt(sz, wd), tag, "write data", cap_wdata, rev_fmt(sz, wd));
        chk(lat == 1, tag, "write ack latency", 32'(lat), 32'd1);
      end else begin
        chk(rd == rev_fmt(sz, resp), tag, "read data", rd, rev_fmt(sz, resp));
      end
    end else begin
      chk(lat == 1, tag, "drop ack latency", 32'(lat), 32'd1);
      if (!we) chk(rd == exp_fill(sz), tag, "fill data", rd, exp_fill(sz));
    end
  endtask

  function automatic string tag_of(input bit we, input logic [1:0] sz, input logic [31:0] a);
    logic [7:0] s;
    s = a[11:4];
    if (sz == 2'd3) return "R12";
    if (sz == 2'd0) begin
      if (s >= 8'd1 && s <= 8'd7) return we ? "R2" : "R4";
      if (s == 8'd8 || s == 8'd22) return "R3";
      return "R5";
    end
    if (s != 8'd0) return "R6";
    return (sz == 2'd1) ? "R7" : "R8";
  endfunction

  initial begin
    int lat;
    bit saw_ack;
    void'($urandom(32'd1234));
    #1;
    // reset state (R11)
    chk(hst_ack == 1'b0 && tf_req == 1'b0, "R11", "reset outputs", {30'h0, hst_ack, tf_req}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hst_rdata == 32'h0, "R11", "reset rdata", hst_rdata, 32'h0);

    // directed corners
    do_acc("R1",  1'b1, 2'd0, 32'hABC0_001F, 32'h0000_005A, 32'h0, 0);
    do_acc("R2",  1'b1, 2'd0, 32'h0000_0070, 32'hFFFF_FF3C, 32'h0, 0);
    do_acc("R3",  1'b1, 2'd0, 32'h0000_0080, 32'h0000_0006, 32'h0, 0);
    do_acc("R3",  1'b1, 2'd0, 32'h0000_0160, 32'h0000_0002, 32'h0, 0);
    do_acc("R3",  1'b0, 2'd0, 32'h0000_0168, 32'h0, 32'h7777_77C3, 1);
    do_acc("R4",  1'b0, 2'd0, 32'h0000_0030, 32'h0, 32'h1234_5678, 0);
    do_acc("R5",  1'b0, 2'd0, 32'h0000_0090, 32'h0, 32'h0, 0);
    do_acc("R5",  1'b1, 2'd0, 32'h0000_0000, 32'h0000_0011, 32'h0, 0);
    do_acc("R5",  1'b1, 2'd0, 32'h0000_0FF0, 32'h0000_0022, 32'h0, 0);
    do_acc("R7",  1'b1, 2'd1, 32'h0000_0002, 32'h0000_AABB, 32'h0, 0);
    do_acc("R7",  1'b0, 2'd1, 32'h0000_0000, 32'h0, 32'h0000_1234, 2);
    do_acc("R6",  1'b0, 2'd1, 32'h0000_0010, 32'h0, 32'h0, 0);
    do_acc("R6",  1'b1, 2'd2, 32'h0000_0020, 32'h1111_1111, 32'h0, 0);
    do_acc("R8",  1'b1, 2'd2, 32'h0000_1000, 32'h1122_3344, 32'h0, 0);
    do_acc("R8",  1'b0, 2'd2, 32'h0000_0004, 32'h0, 32'hA1B2_C3D4, 3);
    do_acc("R6",  1'b0, 2'd2, 32'h0000_0050, 32'h0, 32'h0, 0);
    do_acc("R12", 1'b1, 2'd3, 32'h0000_0000, 32'h5555_5555, 32'h0, 0);
    do_acc("R12", 1'b0, 2'd3, 32'h0000_0000, 32'h0, 32'h0, 0);
    do_acc("R10", 1'b0, 2'd0, 32'h0000_0020, 32'h0, 32'h0000_00E1, 5);

    // R11: reset while a read waits, stale response must not acknowledge
    resp_word = 32'h0000_0099;
    resp_delay = 4;
    @(negedge clk);
    hst_req = 1'b1; hst_we = 1'b0; hst_size = 2'd0; hst_addr = 32'h0000_0010;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    hst_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(hst_ack == 1'b0 && tf_req == 1'b0, "R11", "after reset", {30'h0, hst_ack, tf_req}, 32'h0);
    saw_ack = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (hst_ack) saw_ack = 1'b1;
    end
    chk(!saw_ack, "R11", "stale response ack", 32'(saw_ack), 32'h0);
    do_acc("R11", 1'b0, 2'd0, 32'h0000_0050, 32'h0, 32'h0000_0042, 0);

    // random traffic (R9, R10 across all routes)
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  s;
      logic [31:0] a;
      logic [1:0]  sz;
      bit          we;
      case ($urandom % 6)
        0: s = 8'd0;
        1: s = 8'(1 + ($urandom % 7));
        2: s = 8'd8;
        3: s = 8'd22;
        4: s = 8'($urandom);
        default: s = 8'(9 + ($urandom % 7));
      endcase
      a  = {20'($urandom), s, 4'($urandom)};
      sz = 2'($urandom);
      we = 1'($urandom);
      lat = int'($urandom % 4);
      do_acc(tag_of(we, sz, a), we, sz, a, $urandom, $urandom, lat);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule